// File: doc/BRIEF.md
# Dual-Channel Shadowed Configuration Register Bank

This block is the register file that sits behind the serial control port of a two-channel converter. The serial front end has already decoded each access into a write strobe or a read strobe, an 8-bit address and 8-bit data. The bank holds two kinds of register. Global registers exist once. Local registers are replicated for each channel, and a channel-select mask decides which copies a local write reaches.

Configuration writes do not reach the hardware directly. They land in master (shadow) copies. A transfer command then moves every master value into the active (slave) copies in a single clock edge, so a set of related settings can change together. The active copies drive the per-channel power controls and the clock duty-cycle stabilizer enable. The port configuration, the channel mask and the transfer command act as soon as they are written. A soft reset written to the port configuration returns the whole bank to its defaults.

Read data is registered and appears one cycle after the read strobe.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset the registers read as follows: 0x00 reads 0x18, 0x05 reads 0x03, 0x08 reads 0x00, 0x09 reads 0x01 and 0xFF reads 0x00. The active outputs are power mode 00 on both channels, pin function 0, stabilizer enabled and LSB-first off.
- R2: Address 0x00 stores the bit-order setting. A write sets it when bit 6 or bit 1 is 1 and clears it otherwise, and `lsb_first_o` follows immediately. A read returns the setting in both bit 6 and bit 1, the soft-reset state in both bit 5 and bit 2, 1 in bits 4 and 3, and 0 in bits 7 and 0.
- R3: A write to 0x00 with bit 5 or bit 2 set raises `soft_rst_o` for exactly one cycle. On the next edge every master and slave register, the channel mask, the transfer bit and the bit-order setting return to their R1 values.
- R4: Address 0x01 always reads 0x9C (parameter `CHIP_ID`), and writes to it are ignored.
- R5: Address 0x02 is read-only. It returns the speed-grade code (parameter `GRADE_CODE`, default 3'b100 for the lower grade; 3'b101 is the higher grade) in bits [6:4] and 0 in every other bit.
- R6: Address 0x05 holds the channel mask in bits [1:0]: bit 0 selects channel A and bit 1 selects channel B. A write takes effect for the very next access. A local write updates the master copy of every selected channel and of no other channel, so a mask of 0 discards local writes.
- R7: Local register 0x08 has two fields. Bits [1:0] are the power mode: 00 normal, 01 full power-down, 10 standby, 11 digital reset. Bit 5 is the external pin function: 0 power-down, 1 standby. All other bits read 0.
- R8: Writes to 0x08 and 0x09 change only the master copies. `pwr_mode_o`, `pin_stby_o` and `dcs_en_o` keep their values until a transfer.
- R9: Writing 1 to bit 0 of 0xFF sets the transfer bit, and a read in the next cycle returns 0x01. On the following edge every slave copy takes its master's value and the bit clears, so later reads return 0x00.
- R10: A read of 0x08 returns the channel A master copy when mask bit 0 is set, and the channel B master copy otherwise.
- R11: Bit 0 of global register 0x09 is the duty-cycle stabilizer enable. It defaults to 1, and `dcs_en_o` shows its active copy.
- R12: Unsupported addresses read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; data is valid the next cycle |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pwr_mode_o | output | 2*NCH | Active power mode of each channel, channel A in bits [1:0] |
| pin_stby_o | output | NCH | Active external pin function of each channel (1 = standby) |
| dcs_en_o | output | 1 | Active duty-cycle stabilizer enable |
| lsb_first_o | output | 1 | Serial bit order is LSB-first |
| soft_rst_o | output | 1 | Soft reset pulse, one cycle |

## Verification
The assertions check several properties on every cycle. Each slave copy holds its value on any cycle without a transfer and takes exactly the previous master value on a transfer. The soft reset and transfer flags are single-cycle pulses. A soft reset leaves the mask, the bit order and every shadow register at their defaults. The identity and grade reads never change. Unsupported addresses read zero.

Other behaviour only the bench's scenarios can show:
- the mirrored bit positions of the port register;
- steering of local writes by each mask value, including a mask of zero;
- which channel's copy a local read returns;
- the field packing of the power register;
- the complete sequence of master, then transfer, then active outputs.

// File: rtl/cfg_shadow_pkg.sv
// Package: shared addresses, field types and packing helpers for the
// shadowed configuration bank. Assumes an 8-bit register address space.
package cfg_shadow_pkg;

    localparam logic [7:0] ADDR_PORT  = 8'h00;
    localparam logic [7:0] ADDR_ID    = 8'h01;
    localparam logic [7:0] ADDR_GRADE = 8'h02;
    localparam logic [7:0] ADDR_INDEX = 8'h05;
    localparam logic [7:0] ADDR_POWER = 8'h08;
    localparam logic [7:0] ADDR_CLOCK = 8'h09;
    localparam logic [7:0] ADDR_XFER  = 8'hFF;

    typedef enum logic [1:0] {
        PWR_NORMAL    = 2'b00,
        PWR_FULL_DOWN = 2'b01,
        PWR_STANDBY   = 2'b10,
        PWR_DIG_RESET = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic      pin_stby;
        pwr_mode_e mode;
    } local_cfg_t;

    localparam int LOCAL_W = $bits(local_cfg_t);
    localparam local_cfg_t LOCAL_DEFAULT = '{pin_stby: 1'b0, mode: PWR_NORMAL};

    // Place local fields at their register bit positions.
    function automatic logic [7:0] pack_local(input local_cfg_t c);
        return {2'b00, c.pin_stby, 3'b000, c.mode};
    endfunction

    // Extract local fields from a write byte; reserved bits are dropped.
    function automatic local_cfg_t unpack_local(input logic [7:0] d);
        local_cfg_t c;
        c.pin_stby = d[5];
        c.mode     = pwr_mode_e'(d[1:0]);
        return c;
    endfunction

    // Build the mirrored port configuration byte.
    function automatic logic [7:0] pack_port(input logic lsb, input logic srst);
        return {1'b0, lsb, srst, 1'b1, 1'b1, srst, lsb, 1'b0};
    endfunction

endpackage

// File: rtl/cfg_shadow_reg.sv
// Module: one master/slave register pair. The master takes writes; the
// slave copies the master on a transfer pulse. Reset or soft reset returns
// both to RST_VAL. Assumes the transfer and soft reset inputs are pulses.
module cfg_shadow_reg #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst_i,
    input  logic         we_i,
    input  logic [W-1:0] wd_i,
    input  logic         xfer_i,
    output logic [W-1:0] master_o,
    output logic [W-1:0] slave_o
);

    // Master capture and slave update on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_i) begin
            master_o <= RST_VAL;
            slave_o  <= RST_VAL;
        end else begin
            if (we_i)
                master_o <= wd_i;
            if (xfer_i)
                slave_o <= master_o;
        end
    end

    // R8: active copy holds without a transfer
    p_slave_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_i && !srst_i) |=> $stable(slave_o));

    // R9: transfer copies the prior master value
    p_slave_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !srst_i) |=> (slave_o == $past(master_o)));

    // R3: soft reset restores both copies
    p_pair_srst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (master_o == RST_VAL && slave_o == RST_VAL));

endmodule

// File: rtl/cfg_port_ctrl.sv
// Module: registers that act immediately. It holds the bit-order flag, the
// soft reset pulse, the channel mask and the transfer pulse. Assumes at
// most one write strobe per cycle and NCH no larger than 8.
module cfg_port_ctrl
    import cfg_shadow_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     addr,
    input  logic [7:0]     wdata,
    output logic           lsb_first_o,
    output logic           soft_rst_o,
    output logic [NCH-1:0] idx_o,
    output logic           xfer_o
);

    logic wr_port, wr_index, wr_xfer, clr;

    // Decode the writes this module owns.
    always_comb begin
        wr_port  = wr_en && (addr == ADDR_PORT);
        wr_index = wr_en && (addr == ADDR_INDEX);
        wr_xfer  = wr_en && (addr == ADDR_XFER);
        clr      = !rst_n || soft_rst_o;
    end

    // Bit order and channel mask.
    always_ff @(posedge clk) begin
        if (clr) begin
            lsb_first_o <= 1'b0;
            idx_o       <= '1;
        end else if (wr_port) begin
            lsb_first_o <= wdata[6] | wdata[1];
        end else if (wr_index) begin
            idx_o <= wdata[NCH-1:0];
        end
    end

    // Soft reset pulse, self-clearing.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_o)
            soft_rst_o <= 1'b0;
        else if (wr_port)
            soft_rst_o <= wdata[5] | wdata[2];
    end

    // Transfer pulse, cleared after the copy edge.
    always_ff @(posedge clk) begin
        if (clr || xfer_o)
            xfer_o <= 1'b0;
        else if (wr_xfer)
            xfer_o <= wdata[0];
    end

    // R3: soft reset lasts one cycle
    p_srst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R3: soft reset restores mask and bit order
    p_srst_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (idx_o == '1 && !lsb_first_o && !xfer_o));

    // R9: transfer bit clears after one cycle
    p_xfer_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> !xfer_o);

endmodule

// File: rtl/cfg_read_mux.sv
// Module: combinational read decode. It assembles the byte for the
// addressed register from the master copies and the control state.
// Unsupported addresses return zero.
module cfg_read_mux
    import cfg_shadow_pkg::*;
#(
    parameter int         NCH        = 2,
    parameter logic [7:0] CHIP_ID    = 8'h9C,
    parameter logic [2:0] GRADE_CODE = 3'b100
) (
    input  logic [7:0]           addr,
    input  logic                 lsb_first_i,
    input  logic                 soft_rst_i,
    input  logic [NCH-1:0]       idx_i,
    input  logic                 xfer_i,
    input  logic [NCH*LOCAL_W-1:0] local_master_i,
    input  logic                 dcs_master_i,
    output logic [7:0]           rd_word_o
);

    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [SEL_W-1:0] sel;
    local_cfg_t       shown;

    // Choose the lowest selected channel, else the last one.
    always_comb begin
        sel = SEL_W'(NCH - 1);
        for (int i = NCH - 1; i >= 0; i--)
            if (idx_i[i])
                sel = SEL_W'(i);
        shown = local_cfg_t'(local_master_i[sel*LOCAL_W +: LOCAL_W]);
    end

    // Address decode into the read byte.
    always_comb begin
        case (addr)
            ADDR_PORT:  rd_word_o = pack_port(lsb_first_i, soft_rst_i);
            ADDR_ID:    rd_word_o = CHIP_ID;
            ADDR_GRADE: rd_word_o = {1'b0, GRADE_CODE, 4'b0000};
            ADDR_INDEX: rd_word_o = 8'(idx_i);
            ADDR_POWER: rd_word_o = pack_local(shown);
            ADDR_CLOCK: rd_word_o = {7'b0, dcs_master_i};
            ADDR_XFER:  rd_word_o = {7'b0, xfer_i};
            default:    rd_word_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/cfg_shadow_bank.sv
// Module: top of the shadowed configuration bank. It takes decoded
// register strobes and holds global and per-channel local registers as
// master/slave pairs. It drives the active controls. Assumes wr_en and
// rd_en are never high in the same cycle.
module cfg_shadow_bank
    import cfg_shadow_pkg::*;
#(
    parameter int         NCH        = 2,
    parameter logic [7:0] CHIP_ID    = 8'h9C,
    parameter logic [2:0] GRADE_CODE = 3'b100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata_o,
    output logic [2*NCH-1:0] pwr_mode_o,
    output logic [NCH-1:0]   pin_stby_o,
    output logic             dcs_en_o,
    output logic             lsb_first_o,
    output logic             soft_rst_o
);

    logic [NCH-1:0]         idx;
    logic                   xfer;
    logic [NCH*LOCAL_W-1:0] local_master;
    logic                   dcs_master;
    logic [7:0]             rd_word;
    local_cfg_t             local_wd;

    // Extract local fields from the write byte.
    always_comb local_wd = unpack_local(wdata);

    cfg_port_ctrl #(.NCH(NCH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .lsb_first_o (lsb_first_o),
        .soft_rst_o  (soft_rst_o),
        .idx_o       (idx),
        .xfer_o      (xfer)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [LOCAL_W-1:0] slave_bits;
        local_cfg_t         slave_cfg;

        cfg_shadow_reg #(.W(LOCAL_W), .RST_VAL(LOCAL_DEFAULT)) u_local (
            .clk      (clk),
            .rst_n    (rst_n),
            .srst_i   (soft_rst_o),
            .we_i     (wr_en && (addr == ADDR_POWER) && idx[ch]),
            .wd_i     (local_wd),
            .xfer_i   (xfer),
            .master_o (local_master[ch*LOCAL_W +: LOCAL_W]),
            .slave_o  (slave_bits)
        );

        // Unpack the active copy onto the channel outputs.
        always_comb begin
            slave_cfg                = local_cfg_t'(slave_bits);
            pwr_mode_o[2*ch +: 2]    = slave_cfg.mode;
            pin_stby_o[ch]           = slave_cfg.pin_stby;
        end
    end

    cfg_shadow_reg #(.W(1), .RST_VAL(1'b1)) u_clock (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_i   (soft_rst_o),
        .we_i     (wr_en && (addr == ADDR_CLOCK)),
        .wd_i     (wdata[0]),
        .xfer_i   (xfer),
        .master_o (dcs_master),
        .slave_o  (dcs_en_o)
    );

    cfg_read_mux #(.NCH(NCH), .CHIP_ID(CHIP_ID), .GRADE_CODE(GRADE_CODE)) u_rmux (
        .addr           (addr),
        .lsb_first_i    (lsb_first_o),
        .soft_rst_i     (soft_rst_o),
        .idx_i          (idx),
        .xfer_i         (xfer),
        .local_master_i (local_master),
        .dcs_master_i   (dcs_master),
        .rd_word_o      (rd_word)
    );

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= 8'h00;
        else if (rd_en)
            rdata_o <= rd_word;
    end

    // R4: identity read is constant
    p_id_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_ID) |=> (rdata_o == CHIP_ID));

    // R5: grade read carries only the code
    p_grade_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_GRADE) |=> (rdata_o[6:4] == GRADE_CODE && rdata_o[7] == 1'b0 && rdata_o[3:0] == 4'h0));

    // R12: unsupported addresses read zero
    p_unsup_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_PORT && addr != ADDR_ID && addr != ADDR_GRADE &&
         addr != ADDR_INDEX && addr != ADDR_POWER && addr != ADDR_CLOCK && addr != ADDR_XFER)
        |=> (rdata_o == 8'h00));

endmodule

// File: tb/cfg_shadow_bank_tb.sv
module cfg_shadow_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata_o;
    logic [3:0] pwr_mode_o;
    logic [1:0] pin_stby_o;
    logic       dcs_en_o;
    logic       lsb_first_o;
    logic       soft_rst_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cfg_shadow_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata_o     (rdata_o),
        .pwr_mode_o  (pwr_mode_o),
        .pin_stby_o  (pin_stby_o),
        .dcs_en_o    (dcs_en_o),
        .lsb_first_o (lsb_first_o),
        .soft_rst_o  (soft_rst_o)
    );

    typedef struct packed {
        logic       is_rd;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 8'h18, 8'd1},   // R1 port default
        '{1'b1, 8'h05, 8'h03, 8'd1},   // R1 mask default
        '{1'b1, 8'h08, 8'h00, 8'd1},   // R1 power default
        '{1'b1, 8'h09, 8'h01, 8'd11},  // R11 stabilizer default
        '{1'b1, 8'hFF, 8'h00, 8'd1},   // R1 transfer default
        '{1'b1, 8'h01, 8'h9C, 8'd4},   // R4 id
        '{1'b0, 8'h01, 8'h55, 8'd4},   // R4 write ignored
        '{1'b1, 8'h01, 8'h9C, 8'd4},   // R4
        '{1'b1, 8'h02, 8'h40, 8'd5},   // R5 grade
        '{1'b0, 8'h02, 8'hFF, 8'd5},   // R5 write ignored
        '{1'b1, 8'h02, 8'h40, 8'd5},   // R5
        '{1'b0, 8'h00, 8'h02, 8'd2},   // R2 via bit 1
        '{1'b1, 8'h00, 8'h5A, 8'd2},   // R2 mirrored
        '{1'b0, 8'h00, 8'h81, 8'd2},   // R2 bits 7,0 ignored
        '{1'b1, 8'h00, 8'h18, 8'd2},   // R2
        '{1'b0, 8'h00, 8'h40, 8'd2},   // R2 via bit 6
        '{1'b1, 8'h00, 8'h5A, 8'd2},   // R2
        '{1'b0, 8'h05, 8'h01, 8'd6},   // R6 select A
        '{1'b0, 8'h08, 8'hFF, 8'd7},   // R7 all ones
        '{1'b1, 8'h08, 8'h23, 8'd7},   // R7 packing
        '{1'b0, 8'h05, 8'h02, 8'd6},   // R6 select B
        '{1'b1, 8'h08, 8'h00, 8'd10},  // R10 B copy untouched
        '{1'b0, 8'h08, 8'h0A, 8'd7},   // R7 standby, bit 3 dropped
        '{1'b1, 8'h08, 8'h02, 8'd6},   // R6 B written
        '{1'b0, 8'h05, 8'h03, 8'd6},   // R6 both
        '{1'b1, 8'h08, 8'h23, 8'd10},  // R10 A shown when both
        '{1'b0, 8'h09, 8'h00, 8'd11},  // R11 disable
        '{1'b1, 8'h09, 8'h00, 8'd11},  // R11 master readback
        '{1'b0, 8'h33, 8'h77, 8'd12},  // R12 unsupported write
        '{1'b1, 8'h33, 8'h00, 8'd12},  // R12 unsupported read
        '{1'b1, 8'h05, 8'h03, 8'd12},  // R12 no side effect
        '{1'b0, 8'h05, 8'hFC, 8'd6},   // R6 mask 0
        '{1'b1, 8'h05, 8'h00, 8'd6},   // R6
        '{1'b0, 8'h08, 8'h01, 8'd6},   // R6 discarded
        '{1'b0, 8'h05, 8'h03, 8'd6},   // R6
        '{1'b1, 8'h08, 8'h23, 8'd6},   // R6 A unchanged
        '{1'b1, 8'h03, 8'h00, 8'd12}   // R12 gap address
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 active outputs after reset
        check(1, {4'h0, pwr_mode_o}, 8'h00, "power outputs after reset");
        check(1, {6'h0, pin_stby_o}, 8'h00, "pin function after reset");
        check(1, {7'h0, dcs_en_o}, 8'h01, "stabilizer after reset");
        check(1, {7'h0, lsb_first_o}, 8'h00, "bit order after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) begin
                do_read(VEC[i].a);
                check(int'(VEC[i].req), rdata_o, VEC[i].d, $sformatf("vector %0d", i));
            end else begin
                do_write(VEC[i].a, VEC[i].d);
            end
        end

        // R2 bit order output follows immediately
        check(2, {7'h0, lsb_first_o}, 8'h01, "lsb_first output");

        // R8 masters written, active copies unchanged
        check(8, {4'h0, pwr_mode_o}, 8'h00, "power before transfer");
        check(8, {6'h0, pin_stby_o}, 8'h00, "pin before transfer");
        check(8, {7'h0, dcs_en_o}, 8'h01, "stabilizer before transfer");

        // R9 transfer: bit reads 1 next cycle, copy on following edge
        do_write(8'hFF, 8'h01);
        check(8, {4'h0, pwr_mode_o}, 8'h00, "power in transfer cycle");
        do_read(8'hFF);
        check(9, rdata_o, 8'h01, "transfer bit set");
        check(9, {4'h0, pwr_mode_o}, 8'h0B, "power after transfer");
        check(9, {6'h0, pin_stby_o}, 8'h01, "pin after transfer");
        check(11, {7'h0, dcs_en_o}, 8'h00, "stabilizer after transfer");
        do_read(8'hFF);
        check(9, rdata_o, 8'h00, "transfer bit cleared");

        // R3 soft reset via bit 5
        do_write(8'h00, 8'h20);
        check(3, {7'h0, soft_rst_o}, 8'h01, "soft reset raised");
        @(negedge clk);
        check(3, {7'h0, soft_rst_o}, 8'h00, "soft reset single cycle");
        check(3, {4'h0, pwr_mode_o}, 8'h00, "power after soft reset");
        check(3, {6'h0, pin_stby_o}, 8'h00, "pin after soft reset");
        check(3, {7'h0, dcs_en_o}, 8'h01, "stabilizer after soft reset");
        check(3, {7'h0, lsb_first_o}, 8'h00, "bit order after soft reset");
        do_read(8'h05);
        check(3, rdata_o, 8'h03, "mask after soft reset");
        do_read(8'h08);
        check(3, rdata_o, 8'h00, "power master after soft reset");
        do_read(8'h09);
        check(3, rdata_o, 8'h01, "clock master after soft reset");
        do_read(8'h00);
        check(3, rdata_o, 8'h18, "port after soft reset");

        // R3 soft reset via bit 2, readback during pulse
        do_write(8'h00, 8'h04);
        do_read(8'h00);
        check(3, rdata_o, 8'h3C, "port during soft reset");
        check(3, {7'h0, soft_rst_o}, 8'h00, "bit 2 pulse ended");

        finish_run();
    end

endmodule